// File: doc/BRIEF.md
# Bidirectional Split-Mode Scan Shift Register

This block is the row-scan register of a common-side display driver with 160 outputs. A scan bit enters at one end of a chain and moves one position on every rising edge of the shift clock, so that one row at a time is selected. The register bits drive the row selectors directly. The end bits leave through pins so that several drivers can be cascaded.

Two static control inputs set the topology. `dual` chooses one 160-bit chain (low) or two independent 80-bit halves (high). `reverse` sets the direction. Each chain end has a pin that acts as an input or an output, depending on the direction. The bench models each pin as three signals: an input, an output and an output enable. A pin whose enable is low drives 0 on its output and is treated as high impedance. Positions are numbered 1 to 160, and position k is bit k-1 of `q`. Pin A sits at position 1, pin B at position 160, pin C at position 80 and pin D at position 81. Pins C and D are used only in dual mode.

Top module: `scan_shift_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears all 160 bits of `q` to 0.
- R2: Single forward mode (`dual`=0, `reverse`=0): on each edge, position 1 loads `a_in`, and every position k>1 loads the old value of position k-1.
- R3: Single reverse mode (`dual`=0, `reverse`=1): on each edge, position 160 loads `b_in`, and every position k<160 loads the old value of position k+1.
- R4: Dual forward mode: positions 1..80 shift upward with `a_in` entering at position 1. Positions 81..160 shift upward with `d_in` entering at position 81. Position 81 never takes the old value of position 80.
- R5: Dual reverse mode: positions 160..81 shift downward with `b_in` entering at position 160. Positions 80..1 shift downward with `c_in` entering at position 80. Position 80 never takes the old value of position 81.
- R6: When `reverse`=0, `b_out` equals position 160. In dual mode `c_out` also equals position 80.
- R7: When `reverse`=1, `a_out` equals position 1. In dual mode `d_out` also equals position 81.
- R8: The output enables are set as follows. `a_oe` equals `reverse`. `b_oe` equals the inverse of `reverse`. `c_oe` is high only in dual forward mode. `d_oe` is high only in dual reverse mode. Any pin whose enable is low drives 0 on its output.
- R9: In single mode, `c_in` and `d_in` have no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous clear |
| dual | input | 1 | 1 = two 80-bit chains, 0 = one 160-bit chain |
| reverse | input | 1 | 1 = shift toward position 1 |
| a_in | input | 1 | Pin A input (position 1 end) |
| b_in | input | 1 | Pin B input (position 160 end) |
| c_in | input | 1 | Pin C input (position 80 end, dual only) |
| d_in | input | 1 | Pin D input (position 81 end, dual only) |
| q | output | 160 | Register bits, bit k-1 = position k |
| a_out | output | 1 | Pin A output value |
| a_oe | output | 1 | Pin A output enable |
| b_out | output | 1 | Pin B output value |
| b_oe | output | 1 | Pin B output enable |
| c_out | output | 1 | Pin C output value |
| c_oe | output | 1 | Pin C output enable |
| d_out | output | 1 | Pin D output value |
| d_oe | output | 1 | Pin D output enable |

## Verification
The shift assertions compare a position with its neighbour or pin on the previous edge. They therefore assume that `dual` and `reverse` held the same values on that previous edge, and each such assertion includes that condition in its antecedent. The bench changes mode only at falling edges, between phases. A reset is always applied across a mode change, except in one phase where the mode is swapped while a pattern is still in flight. That phase is checked against the reference model alone. Pin inputs that the current mode does not use are driven with random values so that any leakage into `q` shows up.

// File: rtl/scan_shift_reg.sv
module scan_shift_reg #(
  parameter int N = 160
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dual,
  input  logic         reverse,
  input  logic         a_in,
  input  logic         b_in,
  input  logic         c_in,
  input  logic         d_in,
  output logic [N-1:0] q,
  output logic         a_out,
  output logic         a_oe,
  output logic         b_out,
  output logic         b_oe,
  output logic         c_out,
  output logic         c_oe,
  output logic         d_out,
  output logic         d_oe
);
  localparam int H = N / 2;

  logic [N-1:0] nxt;

  always_comb begin
    if (!reverse) begin
      nxt = {q[N-2:0], a_in};
      if (dual) nxt[H] = d_in;
    end else begin
      nxt = {b_in, q[N-1:1]};
      if (dual) nxt[H-1] = c_in;
    end
  end

  always_ff @(posedge clk)
    if (rst) q <= '0;
    else     q <= nxt;

  assign a_oe  = reverse;
  assign b_oe  = !reverse;
  assign c_oe  = dual && !reverse;
  assign d_oe  = dual && reverse;
  assign a_out = a_oe && q[0];
  assign b_out = b_oe && q[N-1];
  assign c_out = c_oe && q[H-1];
  assign d_out = d_oe && q[H];
endmodule

module scan_shift_reg_chk #(
  parameter int N = 160
) (
  input logic         clk,
  input logic         rst,
  input logic         dual,
  input logic         reverse,
  input logic         a_in,
  input logic         b_in,
  input logic         c_in,
  input logic         d_in,
  input logic [N-1:0] q,
  input logic         a_out,
  input logic         a_oe,
  input logic         b_out,
  input logic         b_oe,
  input logic         c_out,
  input logic         c_oe,
  input logic         d_out,
  input logic         d_oe
);
  localparam int H = N / 2;

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> q == '0);

  assert_fwd_entry_R2: assert property (@(posedge clk) disable iff (rst)
    !reverse |=> q[0] == $past(a_in));

  assert_fwd_carry_R2: assert property (@(posedge clk) disable iff (rst)
    !reverse && !dual |=> q[H] == $past(q[H-1]));

  assert_rev_entry_R3: assert property (@(posedge clk) disable iff (rst)
    reverse |=> q[N-1] == $past(b_in));

  assert_rev_carry_R3: assert property (@(posedge clk) disable iff (rst)
    reverse && !dual |=> q[H-1] == $past(q[H]));

  assert_dual_fwd_split_R4: assert property (@(posedge clk) disable iff (rst)
    !reverse && dual |=> q[H] == $past(d_in));

  assert_dual_rev_split_R5: assert property (@(posedge clk) disable iff (rst)
    reverse && dual |=> q[H-1] == $past(c_in));

  assert_fwd_pin_R6: assert property (@(posedge clk) disable iff (rst)
    !reverse && $past(!reverse) && !$past(rst) |-> b_out == $past(q[N-2]));

  assert_rev_pin_R7: assert property (@(posedge clk) disable iff (rst)
    reverse && $past(reverse) && !$past(rst) |-> a_out == $past(q[1]));

  assert_oe_ab_R8: assert property (@(posedge clk) disable iff (rst)
    a_oe != b_oe);

  assert_oe_cd_R8: assert property (@(posedge clk) disable iff (rst)
    !(c_oe && d_oe) && (dual || (!c_oe && !d_oe)));

  assert_hiz_R8: assert property (@(posedge clk) disable iff (rst)
    (a_oe || !a_out) && (b_oe || !b_out) && (c_oe || !c_out) && (d_oe || !d_out));
endmodule

bind scan_shift_reg scan_shift_reg_chk #(.N(N)) u_chk (.*);

// File: tb/scan_shift_reg_bench.sv
module scan_shift_reg_bench;
  localparam int N = 160;
  localparam int H = N / 2;

  logic clk = 0, rst = 1, dual = 0, reverse = 0;
  logic a_in = 0, b_in = 0, c_in = 0, d_in = 0;
  logic [N-1:0] q;
  logic a_out, a_oe, b_out, b_oe, c_out, c_oe, d_out, d_oe;

  int checks = 0, errors = 0, cycles = 0;
  bit mdl[N];

  always #2.5 clk = ~clk;

  scan_shift_reg #(.N(N)) u_scan_shift_reg (.*);

  always @(posedge clk) begin
    bit old[N];
    old = mdl;
    if (rst) begin
      foreach (mdl[i]) mdl[i] = 0;
    end else if (!reverse) begin
      for (int p = N - 1; p > 0; p--) mdl[p] = old[p-1];
      mdl[0] = a_in;
      if (dual) mdl[H] = d_in;
    end else begin
      for (int p = 0; p < N - 1; p++) mdl[p] = old[p+1];
      mdl[N-1] = b_in;
      if (dual) mdl[H-1] = c_in;
    end
  end

  function automatic string req_tag();
    if (!dual) return reverse ? "R3/R9" : "R2/R9";
    return reverse ? "R5" : "R4";
  endfunction

  task automatic compare(input string tag);
    logic [N-1:0] e;
    logic [7:0] pe, pa;
    foreach (mdl[i]) e[i] = mdl[i];
    checks++;
    if (q !== e) begin
      errors++;
      $display("FAIL %s q actual=%h expected=%h", tag, q, e);
    end
    pe = {reverse, !reverse, dual && !reverse, dual && reverse,
          reverse && e[0], !reverse && e[N-1], dual && !reverse && e[H-1], dual && reverse && e[H]};
    pa = {a_oe, b_oe, c_oe, d_oe, a_out, b_out, c_out, d_out};
    checks++;
    if (pa !== pe) begin
      errors++;
      $display("FAIL R6/R7/R8 pins actual=%b expected=%b", pa, pe);
    end
  endtask

  task automatic run(input int n, input int pattern);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare(req_tag());
      case (pattern)
        0: begin a_in = (k % 20 == 0); b_in = (k % 20 == 0); end
        default: begin a_in = $urandom(); b_in = $urandom(); end
      endcase
      c_in = $urandom();
      d_in = $urandom();
      if (pattern == 2) begin c_in = (k % 7 == 0); d_in = (k % 5 == 0); end
    end
  endtask

  task automatic set_mode(input logic dm, input logic rv);
    @(negedge clk);
    rst = 1; dual = dm; reverse = rv;
    @(negedge clk);
    rst = 0;
    compare("R1");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    set_mode(0, 0); run(200, 0); run(200, 1);
    set_mode(0, 1); run(200, 0); run(200, 1);
    set_mode(1, 0); run(120, 2); run(200, 1);
    set_mode(1, 1); run(120, 2); run(200, 1);
    @(negedge clk); dual = 0; reverse = 0; run(100, 1);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    compare("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule